// File: doc/BRIEF.md
# Extender-Fed Ripple Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit of parameterised width (four bits by default). A single ripple chain of full adders computes every result, including the logic ones. In front of each adder bit sits an extender stage that builds the two adder operands from the operand bits and the operation code. A small separate piece of logic picks the carry that enters bit 0.

The operation code is made of a mode bit and a two-bit function select. With the mode bit low, the extender puts the bitwise logic result on the first operand, forces the second operand to zero and holds the entry carry at zero, so the adder passes the logic result through unchanged. With the mode bit high, the extender sets up addition, subtraction, increment or decrement, and the carry logic supplies the entry carry that two's-complement subtraction and increment need. The carry from the top adder is brought out as the only status output.

Top module: `alu_ext_top`

## Requirements
- R1: With mode_arith=0 and sel=2'b00, result equals the bitwise complement of opa.
- R2: With mode_arith=0 and sel=2'b01, result equals opa AND opb.
- R3: With mode_arith=0 and sel=2'b10, result equals opa XOR opb.
- R4: With mode_arith=0 and sel=2'b11, result equals opa OR opb.
- R5: Whenever mode_arith=0, carry_out is 0, the second adder operand is all zeros and the entry carry is 0.
- R6: With mode_arith=1 and sel=2'b00, {carry_out, result} equals opa + opb with WIDTH+1 bits.
- R7: With mode_arith=1 and sel=2'b01, result equals opa - opb modulo 2^WIDTH and carry_out is 1 exactly when opa >= opb (unsigned).
- R8: With mode_arith=1 and sel=2'b10, result equals opa + 1 modulo 2^WIDTH and carry_out is 1 exactly when opa is all ones.
- R9: With mode_arith=1 and sel=2'b11, result equals opa - 1 modulo 2^WIDTH and carry_out is 1 exactly when opa is not zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| mode_arith | input | 1 | 0 selects logic functions, 1 selects arithmetic functions |
| sel | input | 2 | Function select within the mode; sel[1] is the high select bit |
| result | output | WIDTH | Function result |
| carry_out | output | 1 | Carry from the most significant adder bit |

## Verification
Every result is due in the same cycle its inputs are applied, since no register lies between inputs and outputs. The bench changes the operands and code on the rising edge of its clock and compares both outputs with its own integer reference half a period later on the falling edge, so the ripple chain has fully settled. All operation codes are swept against every operand pair at the default width.

// File: rtl/alu_ext_pkg.sv
package alu_ext_pkg;

  typedef enum logic [2:0] {
    OP_NOT = 3'b000,
    OP_AND = 3'b001,
    OP_XOR = 3'b010,
    OP_OR  = 3'b011,
    OP_ADD = 3'b100,
    OP_SUB = 3'b101,
    OP_INC = 3'b110,
    OP_DEC = 3'b111
  } alu_op_e;

  // First adder operand for one bit position
  function automatic logic ext_x_bit(input alu_op_e op, input logic a, input logic b);
    case (op)
      OP_NOT:  ext_x_bit = ~a;
      OP_AND:  ext_x_bit = a & b;
      OP_XOR:  ext_x_bit = a ^ b;
      OP_OR:   ext_x_bit = a | b;
      default: ext_x_bit = a;
    endcase
  endfunction

  // Second adder operand for one bit position
  function automatic logic ext_y_bit(input alu_op_e op, input logic b);
    case (op)
      OP_ADD:  ext_y_bit = b;
      OP_SUB:  ext_y_bit = ~b;
      OP_DEC:  ext_y_bit = 1'b1;
      default: ext_y_bit = 1'b0;
    endcase
  endfunction

  // Carry entering bit 0
  function automatic logic entry_carry(input alu_op_e op);
    entry_carry = (op == OP_SUB) || (op == OP_INC);
  endfunction

endpackage

// File: rtl/alu_ext_slice.sv
module alu_ext_slice
  import alu_ext_pkg::*;
(
  input  alu_op_e op,
  input  logic    a_bit,
  input  logic    b_bit,
  output logic    x_bit,
  output logic    y_bit
);

  always_comb begin
    x_bit = ext_x_bit(op, a_bit, b_bit);
    y_bit = ext_y_bit(op, b_bit);
  end

endmodule

// File: rtl/alu_ext_fa.sv
module alu_ext_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);

  logic half_sum;

  always_comb begin
    half_sum = x ^ y;
    s        = half_sum ^ ci;
    co       = (x & y) | (ci & half_sum);
  end

endmodule

// File: rtl/alu_ext_cin.sv
module alu_ext_cin
  import alu_ext_pkg::*;
(
  input  alu_op_e op,
  output logic    cin
);

  always_comb cin = entry_carry(op);

endmodule

// File: rtl/alu_ext_top.sv
module alu_ext_top
  import alu_ext_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             mode_arith,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);

  localparam int CHAIN = WIDTH + 1;

  alu_op_e          op;
  logic [WIDTH-1:0] x_vec;
  logic [WIDTH-1:0] y_vec;
  logic [CHAIN-1:0] carry_chain;
  logic             cin;

  assign op = alu_op_e'({mode_arith, sel});

  alu_ext_cin u_cin (
    .op  (op),
    .cin (cin)
  );

  assign carry_chain[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    alu_ext_slice u_ext (
      .op    (op),
      .a_bit (opa[i]),
      .b_bit (opb[i]),
      .x_bit (x_vec[i]),
      .y_bit (y_vec[i])
    );
    alu_ext_fa u_fa (
      .x  (x_vec[i]),
      .y  (y_vec[i]),
      .ci (carry_chain[i]),
      .s  (result[i]),
      .co (carry_chain[i+1])
    );
  end

  assign carry_out = carry_chain[WIDTH];

  always_comb begin
    if (!mode_arith) begin
      // R5
      logic_y_zero_chk: assert (y_vec == '0 && cin == 1'b0);
      // R5
      logic_cout_zero_chk: assert (carry_out == 1'b0);
      // R1
      logic_pass_chk: assert (result == x_vec);
    end
    if (op == OP_ADD) begin
      // R6
      add_sum_chk: assert ({carry_out, result} == ({1'b0, opa} + {1'b0, opb}));
    end
    if (op == OP_SUB) begin
      // R7
      sub_borrow_chk: assert (carry_out == (opa >= opb));
    end
    if (op == OP_INC) begin
      // R8
      inc_wrap_chk: assert (carry_out == (&opa));
    end
    if (op == OP_DEC) begin
      // R9
      dec_carry_chk: assert (carry_out == (|opa));
    end
  end

endmodule

// File: tb/alu_ext_top_tb.sv
module alu_ext_top_tb;

  localparam int WIDTH   = 4;
  localparam int CLK_PER = 10;
  localparam int LIMIT   = 100000;

  logic             clk = 1'b0;
  logic [WIDTH-1:0] opa = '0;
  logic [WIDTH-1:0] opb = '0;
  logic             mode_arith = 1'b0;
  logic [1:0]       sel = 2'b00;
  logic [WIDTH-1:0] result;
  logic             carry_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  alu_ext_top #(.WIDTH(WIDTH)) u_dut (
    .opa        (opa),
    .opb        (opb),
    .mode_arith (mode_arith),
    .sel        (sel),
    .result     (result),
    .carry_out  (carry_out)
  );

  function automatic string req_of(input int code);
    case (code)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Behavioural reference: integer arithmetic, returns {carry, result}
  function automatic int model(input int code, input int a, input int b);
    int m   = 1 << WIDTH;
    int r   = 0;
    int cy  = 0;
    case (code)
      0: r = (m - 1) - a;
      1: r = a & b;
      2: r = a ^ b;
      3: r = a | b;
      4: begin r = (a + b) % m; cy = (a + b >= m) ? 1 : 0; end
      5: begin r = (a - b + m) % m; cy = (a >= b) ? 1 : 0; end
      6: begin r = (a + 1) % m; cy = (a == m - 1) ? 1 : 0; end
      default: begin r = (a - 1 + m) % m; cy = (a != 0) ? 1 : 0; end
    endcase
    return cy * m + r;
  endfunction

  task automatic check(input int code, input int a, input int b);
    int exp_all = model(code, a, b);
    int exp_r   = exp_all % (1 << WIDTH);
    int exp_c   = exp_all / (1 << WIDTH);
    checks++;
    if (int'(result) != exp_r) begin
      fails++;
      $display("FAIL %s result code=%0d a=%0d b=%0d actual=%0d expected=%0d",
               req_of(code), code, a, b, result, exp_r);
    end
    checks++;
    if (int'(carry_out) != exp_c) begin
      fails++;
      // R5 covers the carry of codes 0..3
      $display("FAIL %s carry code=%0d a=%0d b=%0d actual=%0d expected=%0d",
               (code < 4) ? "R5" : req_of(code), code, a, b, carry_out, exp_c);
    end
  endtask

  initial begin
    // Power-up input pattern: complement of zero, all ones, carry 0 (R1, R5)
    @(negedge clk);
    check(0, 0, 0);
    for (int code = 0; code < 8; code++) begin
      for (int a = 0; a < (1 << WIDTH); a++) begin
        for (int b = 0; b < (1 << WIDTH); b++) begin
          @(posedge clk);
          mode_arith = code[2];
          sel        = code[1:0];
          opa        = a[WIDTH-1:0];
          opb        = b[WIDTH-1:0];
          @(negedge clk);
          check(code, a, b);
        end
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule